// File: doc/BRIEF.md
# Four-phase time-sliced shared memory arbiter

This block lets three masters share one synchronous single-port memory on a fixed schedule, with no ready or wait signalling. The masters are a video fetcher, a main CPU and an added external CPU. Each system cycle (nominally 1 µs) is cut into four equal sub-slots of `CLKS_PER_SLOT` clocks each. The video fetcher owns the first half of the system cycle and the main CPU owns the second half. Ahead of each of these owners, the arbiter inserts a hidden sub-slot for the external CPU. The memory therefore runs at four accesses per system cycle, and the external CPU gets every second access.

A phase counter picks the owner of each sub-slot. The arbiter loads that owner's address, write data and write intent into registered memory outputs on the first clock of the sub-slot, and holds them for the whole sub-slot. It raises write enable only in the inner clocks of a writing sub-slot. On the last clock of a sub-slot it samples the memory read data into the owner's own read register. The memory must deliver valid data within one sub-slot. The video fetcher and the main CPU simply present addresses and take data at fixed times. The external CPU uses a request/acknowledge pair. Its request is taken at the start of one of its sub-slots, and an acknowledge pulse follows when that sub-slot ends. If the external CPU does not request, its sub-slot leaves the memory idle.

Top module: `tslot_mem_arbiter`

## Requirements
- R1: `slot_phase` steps 00, 01, 10, 11 and wraps, holding each value for `CLKS_PER_SLOT` clocks. 00 and 10 are external-CPU sub-slots, 01 is video and 11 is main CPU. After reset the first sub-slot is phase 00.
- R2: For the whole of a sub-slot, `mem_addr` carries the address the owner presented on the clock edge that began the sub-slot: `vid_addr` in phase 01, `cpu_addr` in phase 11, and `ext_addr` in phases 00 and 10 when an external access is granted. `mem_en` is 1 in every video and CPU sub-slot.
- R3: The video sub-slot never writes. A CPU sub-slot writes `cpu_wdata` when `cpu_we` was 1 at the edge that began it. Otherwise it reads.
- R4: `mem_we` is 0 on the first and last clock of every sub-slot. In a writing sub-slot it is 1 on every clock in between.
- R5: Read data is sampled on the edge that ends a reading sub-slot. `vid_rdata` changes only on the first clock of phase 10, and `cpu_rdata` changes only on the first clock of phase 00.
- R6: `ext_req` is taken on the edge that begins an external sub-slot. `ext_ack` is then high for exactly the one clock after that sub-slot. On a read, `ext_rdata` takes the memory data in that same clock. After a write, and between accesses, `ext_rdata` keeps its value.
- R7: An external sub-slot that begins with `ext_req` at 0 keeps `mem_en` and `mem_we` at 0 throughout. It is not handed to another master.
- R8: While `rst` is high, `slot_phase` is 00, `mem_we`, `mem_en` and `ext_ack` are 0, and `ext_rdata` is 0.
- R9: An external master that re-requests in the clock its acknowledge is seen is served in the next external sub-slot. Back-to-back acknowledges are therefore `2*CLKS_PER_SLOT` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLKS_PER_SLOT` cycles per sub-slot |
| rst | input | 1 | Synchronous active-high reset |
| vid_addr | input | ADDR_W | Video fetcher address |
| vid_rdata | output | DATA_W | Video read data, updated after each video sub-slot |
| cpu_addr | input | ADDR_W | Main CPU address |
| cpu_wdata | input | DATA_W | Main CPU write data |
| cpu_we | input | 1 | Main CPU write request for its sub-slot |
| cpu_rdata | output | DATA_W | Main CPU read data, updated after each CPU read sub-slot |
| ext_req | input | 1 | External CPU request, held until acknowledged |
| ext_we | input | 1 | External CPU write (1) or read (0) |
| ext_addr | input | ADDR_W | External CPU address |
| ext_wdata | input | DATA_W | External CPU write data |
| ext_ack | output | 1 | One-clock pulse when an external access has completed |
| ext_rdata | output | DATA_W | Latched external read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_en | output | 1 | Memory access in progress in this sub-slot |
| mem_rdata | input | DATA_W | Memory read data, registered by the memory |
| slot_phase | output | 2 | Current sub-slot owner code |

## Verification
The bench builds the arbiter with `ADDR_W` = 8, `DATA_W` = 8 and `CLKS_PER_SLOT` = 4. With these values, a bench memory covering the entire address space can be modelled, so any address the table picks can be read back against a known fill pattern. A four-clock sub-slot keeps the entry clock, the two write clocks and the sampling clock apart, so an enable that comes one clock early or late shows up at the ports. A cycle-exact model in the bench follows the phase and the values taken at each sub-slot entry. With it, owner routing, idle external sub-slots, acknowledge timing and the back-to-back service spacing are all compared clock by clock.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  // Sub-slot owner codes, in schedule order.
  typedef enum logic [1:0] {
    SLOT_EXT_A = 2'b00,
    SLOT_VID   = 2'b01,
    SLOT_EXT_B = 2'b10,
    SLOT_CPU   = 2'b11
  } slot_e;

  localparam int NUM_SLOTS = 4;

  function automatic logic is_ext_slot(input slot_e s);
    return ~s[0];
  endfunction

endpackage

// File: rtl/tslot_phase_gen.sv
module tslot_phase_gen
  import tslot_pkg::*;
#(
  parameter int CLKS_PER_SLOT = 4,
  localparam int TW = (CLKS_PER_SLOT > 2) ? $clog2(CLKS_PER_SLOT) : 2
) (
  input  logic  clk,
  input  logic  rst,
  output slot_e phase_q,
  output slot_e phase_nx,
  output logic  enter_nx,
  output logic  slot_last,
  output logic  wr_win_nx
);

  localparam logic [TW-1:0] LAST = TW'(CLKS_PER_SLOT - 1);

  logic [TW-1:0] tick_q;
  logic [TW-1:0] tick_nx;

  always_comb begin
    slot_last = (tick_q == LAST);
    if (slot_last) begin
      tick_nx  = '0;
      phase_nx = slot_e'(phase_q + 2'd1);
    end else begin
      tick_nx  = tick_q + 1'b1;
      phase_nx = phase_q;
    end
    enter_nx  = (tick_nx == '0);
    wr_win_nx = (tick_nx != '0) && (tick_nx != LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      phase_q <= SLOT_EXT_A;
    end else begin
      tick_q  <= tick_nx;
      phase_q <= phase_nx;
    end
  end

endmodule

// File: rtl/tslot_port_mux.sv
module tslot_port_mux
  import tslot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_e             phase_nx,
  input  logic              enter_nx,
  input  logic              wr_win_nx,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              ext_req,
  input  logic              ext_we,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_en,
  output logic              cur_write
);

  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sel_en;
  logic              sel_wr;

  // Owner selection for the sub-slot about to begin.
  always_comb begin
    sel_addr  = ext_addr;
    sel_wdata = '0;
    sel_en    = 1'b0;
    sel_wr    = 1'b0;
    unique case (phase_nx)
      SLOT_VID: begin
        sel_addr = vid_addr;
        sel_en   = 1'b1;
      end
      SLOT_CPU: begin
        sel_addr  = cpu_addr;
        sel_wdata = cpu_wdata;
        sel_en    = 1'b1;
        sel_wr    = cpu_we;
      end
      default: begin
        if (ext_req) begin
          sel_wdata = ext_wdata;
          sel_en    = 1'b1;
          sel_wr    = ext_we;
        end
      end
    endcase
  end

  // Address, data and intent load at entry and hold; strobe in inner clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_en    <= 1'b0;
      cur_write <= 1'b0;
      mem_we    <= 1'b0;
    end else if (enter_nx) begin
      mem_addr  <= sel_addr;
      mem_wdata <= sel_wdata;
      mem_en    <= sel_en;
      cur_write <= sel_en & sel_wr;
      mem_we    <= 1'b0;
    end else begin
      mem_we    <= mem_en & cur_write & wr_win_nx;
    end
  end

endmodule

// File: rtl/tslot_read_capture.sv
module tslot_read_capture
  import tslot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_e             phase_q,
  input  logic              slot_last,
  input  logic              mem_en,
  input  logic              cur_write,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] vid_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              ext_ack
);

  logic [NUM_SLOTS-1:0] cap_stb;
  logic                 ext_done;

  for (genvar p = 0; p < NUM_SLOTS; p++) begin : g_stb
    assign cap_stb[p] = slot_last && mem_en && !cur_write &&
                        (phase_q == slot_e'(2'(p)));
  end

  assign ext_done = slot_last && mem_en && is_ext_slot(phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_rdata <= '0;
      cpu_rdata <= '0;
      ext_rdata <= '0;
      ext_ack   <= 1'b0;
    end else begin
      if (cap_stb[SLOT_VID]) vid_rdata <= mem_rdata;
      if (cap_stb[SLOT_CPU]) cpu_rdata <= mem_rdata;
      if (cap_stb[SLOT_EXT_A] || cap_stb[SLOT_EXT_B]) ext_rdata <= mem_rdata;
      ext_ack <= ext_done;
    end
  end

endmodule

// File: rtl/tslot_mem_arbiter.sv
module tslot_mem_arbiter
  import tslot_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CLKS_PER_SLOT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [DATA_W-1:0] vid_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ext_req,
  input  logic              ext_we,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic              ext_ack,
  output logic [DATA_W-1:0] ext_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        slot_phase
);

  slot_e phase_q;
  slot_e phase_nx;
  logic  enter_nx;
  logic  slot_last;
  logic  wr_win_nx;
  logic  cur_write;

  tslot_phase_gen #(
    .CLKS_PER_SLOT(CLKS_PER_SLOT)
  ) phase_i (
    .clk       (clk),
    .rst       (rst),
    .phase_q   (phase_q),
    .phase_nx  (phase_nx),
    .enter_nx  (enter_nx),
    .slot_last (slot_last),
    .wr_win_nx (wr_win_nx)
  );

  tslot_port_mux #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) mux_i (
    .clk       (clk),
    .rst       (rst),
    .phase_nx  (phase_nx),
    .enter_nx  (enter_nx),
    .wr_win_nx (wr_win_nx),
    .vid_addr  (vid_addr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_en    (mem_en),
    .cur_write (cur_write)
  );

  tslot_read_capture #(
    .DATA_W(DATA_W)
  ) cap_i (
    .clk       (clk),
    .rst       (rst),
    .phase_q   (phase_q),
    .slot_last (slot_last),
    .mem_en    (mem_en),
    .cur_write (cur_write),
    .mem_rdata (mem_rdata),
    .vid_rdata (vid_rdata),
    .cpu_rdata (cpu_rdata),
    .ext_rdata (ext_rdata),
    .ext_ack   (ext_ack)
  );

  assign slot_phase = phase_q;

endmodule

// File: rtl/tslot_mem_arbiter_chk.sv
module tslot_mem_arbiter_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        slot_phase,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_en,
  input logic              ext_ack,
  input logic [DATA_W-1:0] ext_rdata,
  input logic [DATA_W-1:0] vid_rdata,
  input logic [DATA_W-1:0] cpu_rdata
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  // R1: phase only ever advances by one
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (slot_phase != $past(slot_phase)) |-> (slot_phase == $past(slot_phase) + 2'd1));

  // R3: video sub-slot never writes
  a_r3_video_no_write: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (slot_phase == 2'b01) |-> !mem_we);

  // R4: no write strobe on a clock where the address moves
  a_r4_we_addr_stable: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (mem_addr != $past(mem_addr)) |-> !mem_we);

  // R4: a strobe never begins on the first clock of a new phase
  a_r4_we_not_at_entry: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (slot_phase != $past(slot_phase)) |-> !mem_we);

  // R7: write strobe only inside an active access
  a_r7_we_needs_en: assert property (@(posedge clk) disable iff (rst || !past_ok)
    mem_we |-> mem_en);

  // R6: acknowledge lasts a single clock
  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ext_ack |=> !ext_ack);

  // R6: external read data only moves with an acknowledge
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !ext_ack |-> $stable(ext_rdata));

  // R5: video data moves only on entry to phase 10
  a_r5_vid_capture_time: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (vid_rdata != $past(vid_rdata)) |-> (slot_phase == 2'b10 && $past(slot_phase) == 2'b01));

  // R5: CPU data moves only on entry to phase 00
  a_r5_cpu_capture_time: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (cpu_rdata != $past(cpu_rdata)) |-> (slot_phase == 2'b00 && $past(slot_phase) == 2'b11));

endmodule

bind tslot_mem_arbiter tslot_mem_arbiter_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .slot_phase (slot_phase),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .mem_en     (mem_en),
  .ext_ack    (ext_ack),
  .ext_rdata  (ext_rdata),
  .vid_rdata  (vid_rdata),
  .cpu_rdata  (cpu_rdata)
);

// File: tb/tslot_mem_arbiter_tb_top.sv
module tslot_mem_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N  = 4;
  localparam int SYS = 4 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] vid_addr = '0, cpu_addr = '0, ext_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, ext_wdata = '0;
  logic          cpu_we = 1'b0, ext_req = 1'b0, ext_we = 1'b0;
  logic [DW-1:0] vid_rdata, cpu_rdata, ext_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_en, ext_ack;
  logic [1:0]    slot_phase;

  int tests = 0;
  int fails = 0;
  int cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tslot_mem_arbiter #(.ADDR_W(AW), .DATA_W(DW), .CLKS_PER_SLOT(N)) dut_i (
    .clk(clk), .rst(rst),
    .vid_addr(vid_addr), .vid_rdata(vid_rdata),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_en(mem_en),
    .mem_rdata(mem_rdata), .slot_phase(slot_phase)
  );

  // Bench memory: registered read, read-first, filled with addr ^ 8'h3C.
  logic [DW-1:0] sram [256];
  initial for (int i = 0; i < 256; i++) sram[i] = 8'(i) ^ 8'h3C;
  always @(posedge clk) begin
    if (mem_we) sram[mem_addr] <= mem_wdata;
    mem_rdata <= sram[mem_addr];
  end

  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cnt);
    end
  endtask

  // Cycle model: values taken at each sub-slot entry.
  logic          e_en = 0, e_wr = 0, ack_pend = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_wd = '0, p_vid = '0, p_cpu = '0, p_ext = '0;
  always @(negedge clk) begin
    int tick, ph, nph;
    tick = cnt % N;
    ph   = (cnt / N) % 4;
    nph  = ((cnt + 1) / N) % 4;
    if (rst) begin
      e_en = 0; e_wr = 0; ack_pend = 0;
    end else if (!done) begin
      check("R1 phase", slot_phase, ph);
      check("R2/R7 mem_en", mem_en, e_en);
      if (e_en) check("R2 mem_addr", mem_addr, e_addr);
      check("R3/R4 mem_we", mem_we, e_en && e_wr && tick != 0 && tick != N-1);
      if (mem_we) check("R3 mem_wdata", mem_wdata, e_wd);
      check("R6 ack timing", ext_ack, ack_pend);
      if (vid_rdata != p_vid) check("R5 vid capture time", cnt % SYS, 2*N);
      if (cpu_rdata != p_cpu) check("R5 cpu capture time", cnt % SYS, 0);
      if (ext_rdata != p_ext) check("R6 ext_rdata moves with ack", ext_ack, 1);
      ack_pend = (tick == N-1) && (ph % 2 == 0) && e_en;
      if (tick == N-1) begin
        case (nph)
          1: begin e_en = 1; e_wr = 0; e_addr = vid_addr; e_wd = '0; end
          3: begin e_en = 1; e_wr = cpu_we; e_addr = cpu_addr; e_wd = cpu_wdata; end
          default: begin e_en = ext_req; e_wr = ext_we; e_addr = ext_addr; e_wd = ext_wdata; end
        endcase
      end
    end
    p_vid = vid_rdata; p_cpu = cpu_rdata; p_ext = ext_rdata;
  end

  task automatic tick_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ext_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int ack_cyc);
    ext_req = 1; ext_we = we; ext_addr = a; ext_wdata = d;
    do tick_clk(1); while (!ext_ack);
    ack_cyc = cnt;
    ext_req = 0;
  endtask

  task automatic check_reset(input string tag);
    @(negedge clk);
    check({tag, " R8 slot_phase"}, slot_phase, 0);
    check({tag, " R8 mem_we"}, mem_we, 0);
    check({tag, " R8 mem_en"}, mem_en, 0);
    check({tag, " R8 ext_ack"}, ext_ack, 0);
    check({tag, " R8 ext_rdata"}, ext_rdata, 0);
  endtask

  // {we, addr, wdata, expected read}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 8'hA1, 8'h55, 8'h00},
    {1'b1, 8'h02, 8'hAA, 8'h00},
    {1'b0, 8'hA1, 8'h00, 8'h55},
    {1'b0, 8'h02, 8'h00, 8'hAA},
    {1'b0, 8'h10, 8'h00, 8'h2C},
    {1'b1, 8'h10, 8'h0F, 8'h00},
    {1'b0, 8'h10, 8'h00, 8'h0F},
    {1'b0, 8'hFF, 8'h00, 8'hC3}
  };

  initial begin
    int prev_ack, ack_cyc;
    logic [DW-1:0] last_rd;
    tick_clk(3);
    check_reset("init");
    tick_clk(1);
    rst = 0;

    // Idle external sub-slots, video and CPU reads
    vid_addr = 8'h20; cpu_addr = 8'h41;
    tick_clk(2 * SYS + 3);
    check("R5 vid_rdata", vid_rdata, 8'h20 ^ 8'h3C);
    check("R5 cpu_rdata", cpu_rdata, 8'h41 ^ 8'h3C);
    check("R7 ext_rdata untouched while idle", ext_rdata, 0);

    // External table, issued back to back
    prev_ack = 0; last_rd = '0;
    foreach (VEC[i]) begin
      ext_op(VEC[i][24], VEC[i][23:16], VEC[i][15:8], ack_cyc);
      if (i > 0) check("R9 ack spacing", ack_cyc - prev_ack, 2 * N);
      if (!VEC[i][24]) last_rd = VEC[i][7:0];
      check(VEC[i][24] ? "R6 ext_rdata held on write" : "R6 ext read data",
            ext_rdata, last_rd);
      prev_ack = ack_cyc;
    end
    tick_clk(1);
    check("R6 ack single clock", ext_ack, 0);
    tick_clk(3 * SYS);
    check("R6 ext_rdata held between accesses", ext_rdata, last_rd);

    // CPU write, then CPU and video read back
    cpu_addr = 8'h30; cpu_wdata = 8'h99; cpu_we = 1;
    tick_clk(SYS + 2);
    cpu_we = 0; vid_addr = 8'h30;
    tick_clk(2 * SYS + 2);
    check("R3 cpu write read back by cpu", cpu_rdata, 8'h99);
    check("R3 cpu write read back by video", vid_rdata, 8'h99);
    ext_op(1'b0, 8'h30, 8'h00, ack_cyc);
    check("R2 ext sees cpu write", ext_rdata, 8'h99);

    // Reset in the middle of a run
    rst = 1;
    tick_clk(2);
    check_reset("mid");
    tick_clk(1);
    rst = 0;
    ext_op(1'b0, 8'hA1, 8'h00, ack_cyc);
    check("R8 operation after reset", ext_rdata, 8'h55);

    tick_clk(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule